// File: doc/BRIEF.md
# Floating-point load/store multiple address generator

This block turns one multi-register floating-point load/store command into a stream of word addresses. A command carries three mode bits (pre, up, write-back), an 8-bit count field, a precision selector and a 32-bit base value. The block decides whether the encoding is a multi-register transfer, a single-register transfer or an undefined encoding. For a multi-register transfer it sends one word address per cycle over a valid/ready handshake and marks the last one.

The base-register write-back value is presented together with the final address. When the base register is the program counter, the base used is the instruction address plus 8. Single-register transfers and undefined encodings produce no addresses. They each raise a one-cycle flag, so the flag can be handed to the next stage. Memory access, data movement and register-file writes belong to other blocks.

Top module: `lsm_addr_gen`

## Requirements
- R1: A command is accepted only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low whenever `addr_valid` is high, and high when the generator is idle.
- R2: The mode bits {pre,up,wb} are decoded as follows: 010 is unindexed, 011 is increment with write-back and 101 is decrement with write-back. 100 and 110 are single-register transfers, and 000, 001 and 111 are undefined.
- R3: The number of addresses equals the count field for precision codes 0 (single) and 1 (double). For code 2 (extended double) it equals the count field minus 1.
- R4: The first address is the base for the unindexed and increment modes, and the base minus 4 times the count field for the decrement mode. Each later address is the previous one plus 4.
- R5: `addr_last` is high only on the final address of a stream.
- R6: `wb_valid` is high only together with the last address, and only in the two write-back modes. `wb_value` is then the base plus 4 times the count field for increment, or the base minus 4 times the count field for decrement. In unindexed mode `wb_valid` stays low.
- R7: When `cmd_base_is_pc` is high, the base used is `cmd_instr_addr + 8` and `cmd_base` is ignored.
- R8: The following raise `bad_encoding` for exactly one cycle, in the cycle after acceptance, and produce no address: an undefined mode, precision code 3, and an address count of zero (count field 0, or count field 0 or 1 with precision code 2).
- R9: A single-register mode raises `single_xfer` for exactly one cycle, in the cycle after acceptance, and produces no address.
- R10: While `addr_valid` is high and `addr_ready` is low, the address, the last flag and the write-back outputs hold their values.
- R11: After reset, `addr_valid`, `bad_encoding` and `single_xfer` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_pre | input | 1 | Pre-index mode bit |
| cmd_up | input | 1 | Up/down mode bit |
| cmd_wb | input | 1 | Write-back mode bit |
| cmd_prec | input | 2 | 0 single, 1 double, 2 extended double, 3 reserved |
| cmd_count_field | input | 8 | Offset field of the command |
| cmd_base | input | 32 | Base register value |
| cmd_base_is_pc | input | 1 | Base register is the program counter |
| cmd_instr_addr | input | 32 | Address of the command's instruction |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer takes the address |
| addr | output | 32 | Word address |
| addr_last | output | 1 | Final address of the stream |
| wb_valid | output | 1 | Base write-back value valid |
| wb_value | output | 32 | New base register value |
| bad_encoding | output | 1 | Undefined-encoding pulse |
| single_xfer | output | 1 | Single-register-transfer pulse |

## Verification
The assertions check a set of rules on every cycle. No command is taken while a stream is in progress, and outputs hold steady under backpressure. Each handshaken non-final address is followed by one exactly 4 higher, and write-back appears only with the last address. At most one of the two flags or a valid address is active at a time, and a flag never comes with an address. Only the bench scenarios can show the values that depend on the command: the number of addresses for each precision, the decrement start point, the write-back values, the program-counter substitution and the classification of each mode combination.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    MODE_UNDEF  = 3'd0,
    MODE_SINGLE = 3'd1,
    MODE_FLAT   = 3'd2,
    MODE_INC    = 3'd3,
    MODE_DEC    = 3'd4
  } lsm_mode_e;

  localparam logic [1:0] PREC_SGL = 2'd0;
  localparam logic [1:0] PREC_DBL = 2'd1;
  localparam logic [1:0] PREC_EXT = 2'd2;

  // mode bits ordered {pre, up, wb}
  function automatic lsm_mode_e decode_puw(input logic [2:0] puw);
    case (puw)
      3'b010:         decode_puw = MODE_FLAT;
      3'b011:         decode_puw = MODE_INC;
      3'b101:         decode_puw = MODE_DEC;
      3'b100, 3'b110: decode_puw = MODE_SINGLE;
      default:        decode_puw = MODE_UNDEF;
    endcase
  endfunction
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             pre,
  input  logic             up,
  input  logic             wb,
  input  logic [1:0]       prec,
  input  logic [OFF_W-1:0] off,
  output lsm_mode_e        mode,
  output logic [OFF_W-1:0] count
);
  lsm_mode_e raw_mode;
  logic      no_words;

  always_comb begin
    raw_mode = decode_puw({pre, up, wb});
    if (prec == PREC_EXT) begin
      count    = off - OFF_W'(1);
      no_words = (off <= OFF_W'(1));
    end else begin
      count    = off;
      no_words = (off == '0);
    end
    mode = raw_mode;
    if (raw_mode == MODE_FLAT || raw_mode == MODE_INC || raw_mode == MODE_DEC) begin
      if (prec == 2'd3 || no_words) mode = MODE_UNDEF;
    end
  end
endmodule

// File: rtl/lsm_base_calc.sv
module lsm_base_calc
  import lsm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 8
) (
  input  logic [AW-1:0]    base,
  input  logic             use_pc,
  input  logic [AW-1:0]    pc,
  input  logic [OFF_W-1:0] off,
  input  lsm_mode_e        mode,
  output logic [AW-1:0]    start,
  output logic [AW-1:0]    new_base,
  output logic             writes_back
);
  localparam int SPAN_W = OFF_W + 2;
  logic [AW-1:0] eff;
  logic [AW-1:0] span;

  always_comb begin
    eff  = use_pc ? pc + AW'(8) : base;
    span = AW'({off, 2'b00});
    writes_back = (mode == MODE_INC) || (mode == MODE_DEC);
    if (mode == MODE_DEC) begin
      start    = eff - span;
      new_base = eff - span;
    end else begin
      start    = eff;
      new_base = eff + span;
    end
  end

  initial begin
    if (SPAN_W > AW) $error("address width too small for offset span");
  end
endmodule

// File: rtl/lsm_stream.sv
module lsm_stream #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic [CW-1:0] count,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_val,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_last,
  output logic          out_wb_valid,
  output logic [AW-1:0] out_wb_value
);
  logic [CW-1:0] remain;
  logic          wb_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_last     <= 1'b0;
      remain       <= '0;
      wb_en_q      <= 1'b0;
      out_wb_value <= '0;
    end else if (load) begin
      out_valid    <= 1'b1;
      out_addr     <= start;
      out_last     <= (count == CW'(1));
      remain       <= count;
      wb_en_q      <= wb_en;
      out_wb_value <= wb_val;
    end else if (out_valid && out_ready) begin
      if (out_last) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end else begin
        out_addr <= out_addr + AW'(4);
        remain   <= remain - CW'(1);
        out_last <= (remain == CW'(2));
      end
    end
  end

  assign out_wb_valid = out_valid & out_last & wb_en_q;
endmodule

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen
  import lsm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_pre,
  input  logic             cmd_up,
  input  logic             cmd_wb,
  input  logic [1:0]       cmd_prec,
  input  logic [OFF_W-1:0] cmd_count_field,
  input  logic [AW-1:0]    cmd_base,
  input  logic             cmd_base_is_pc,
  input  logic [AW-1:0]    cmd_instr_addr,
  output logic             addr_valid,
  input  logic             addr_ready,
  output logic [AW-1:0]    addr,
  output logic             addr_last,
  output logic             wb_valid,
  output logic [AW-1:0]    wb_value,
  output logic             bad_encoding,
  output logic             single_xfer
);
  lsm_mode_e        mode;
  logic [OFF_W-1:0] count;
  logic [AW-1:0]    start, new_base;
  logic             writes_back;
  logic             accept, streams;

  lsm_decode #(.OFF_W(OFF_W)) dec_i (
    .pre(cmd_pre), .up(cmd_up), .wb(cmd_wb), .prec(cmd_prec),
    .off(cmd_count_field), .mode(mode), .count(count)
  );

  lsm_base_calc #(.AW(AW), .OFF_W(OFF_W)) base_i (
    .base(cmd_base), .use_pc(cmd_base_is_pc), .pc(cmd_instr_addr),
    .off(cmd_count_field), .mode(mode), .start(start),
    .new_base(new_base), .writes_back(writes_back)
  );

  assign cmd_ready = ~addr_valid;
  assign accept    = cmd_valid & cmd_ready;
  assign streams   = (mode == MODE_FLAT) || (mode == MODE_INC) || (mode == MODE_DEC);

  lsm_stream #(.AW(AW), .CW(OFF_W)) strm_i (
    .clk(clk), .rst(rst), .load(accept & streams), .start(start),
    .count(count), .wb_en(writes_back), .wb_val(new_base),
    .out_ready(addr_ready), .out_valid(addr_valid), .out_addr(addr),
    .out_last(addr_last), .out_wb_valid(wb_valid), .out_wb_value(wb_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_encoding <= 1'b0;
      single_xfer  <= 1'b0;
    end else begin
      bad_encoding <= accept && (mode == MODE_UNDEF);
      single_xfer  <= accept && (mode == MODE_SINGLE);
    end
  end
endmodule

// File: rtl/lsm_addr_gen_chk.sv
module lsm_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_ready,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          addr_last,
  input logic          wb_valid,
  input logic [AW-1:0] wb_value,
  input logic          bad_encoding,
  input logic          single_xfer
);
  // R1
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> !cmd_ready);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && addr_ready && !addr_last) |=> (addr_valid && addr == $past(addr) + AW'(4)));

  // R6
  wb_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (addr_valid && addr_last));

  // R8
  undef_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bad_encoding |=> !addr_valid);

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bad_encoding, single_xfer, addr_valid}));

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(addr_last)
                                     && $stable(wb_valid) && $stable(wb_value)));
endmodule

bind lsm_addr_gen lsm_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr(addr), .addr_last(addr_last),
  .wb_valid(wb_valid), .wb_value(wb_value), .bad_encoding(bad_encoding),
  .single_xfer(single_xfer)
);

// File: tb/lsm_addr_gen_tb_top.sv
module lsm_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic        cmd_pre = 1'b0, cmd_up = 1'b0, cmd_wb = 1'b0;
  logic [1:0]  cmd_prec = 2'd0;
  logic [7:0]  cmd_count_field = 8'd0;
  logic [31:0] cmd_base = '0, cmd_instr_addr = '0;
  logic        cmd_base_is_pc = 1'b0;
  logic        addr_valid, addr_ready = 1'b1, addr_last, wb_valid;
  logic [31:0] addr, wb_value;
  logic        bad_encoding, single_xfer;

  typedef struct packed {
    logic [31:0] a;
    logic        last;
    logic        wbv;
    logic [31:0] wbval;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0, n_fail = 0;
  int   cyc = 0;
  bit   done = 0;
  bit   stall_mode = 0;

  always #2.5 clk = ~clk;

  lsm_addr_gen dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pre(cmd_pre), .cmd_up(cmd_up), .cmd_wb(cmd_wb), .cmd_prec(cmd_prec),
    .cmd_count_field(cmd_count_field), .cmd_base(cmd_base),
    .cmd_base_is_pc(cmd_base_is_pc), .cmd_instr_addr(cmd_instr_addr),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .addr_last(addr_last), .wb_valid(wb_valid), .wb_value(wb_value),
    .bad_encoding(bad_encoding), .single_xfer(single_xfer)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready pattern: stalls one cycle in three when stall_mode is set
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 addr_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && addr_valid) begin
      check(!cmd_ready, "R1", "cmd_ready while streaming", {31'd0, cmd_ready}, 32'd0);
      if (addr_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3", "unexpected address", addr, 32'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(addr == e.a, "R4", "address", addr, e.a);
          check(addr_last == e.last, "R5", "last flag", {31'd0, addr_last}, {31'd0, e.last});
          check(wb_valid == e.wbv, "R6", "wb_valid", {31'd0, wb_valid}, {31'd0, e.wbv});
          if (e.wbv)
            check(wb_value == e.wbval, "R6", "wb_value", wb_value, e.wbval);
        end
      end
    end
  end

  // kind: 0 stream, 1 single transfer, 2 undefined
  task automatic run_cmd(input logic [2:0] puw, input logic [1:0] prec,
                         input logic [7:0] off, input logic [31:0] base,
                         input bit use_pc, input logic [31:0] pc,
                         input int kind, input string req);
    logic [31:0] eff, span, start, wbval;
    int          cnt;
    bit          dec, wbm;
    eff   = use_pc ? pc + 32'd8 : base;
    span  = {22'd0, off, 2'b00};
    dec   = (puw == 3'b101);
    wbm   = (puw == 3'b011) || dec;
    cnt   = (prec == 2'd2) ? int'(off) - 1 : int'(off);
    start = dec ? eff - span : eff;
    wbval = dec ? eff - span : eff + span;
    if (kind == 0) begin
      for (int i = 0; i < cnt; i++) begin
        exp_t e;
        e.a     = start + 32'(4 * i);
        e.last  = (i == cnt - 1);
        e.wbv   = e.last && wbm;
        e.wbval = wbval;
        expq.push_back(e);
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    {cmd_pre, cmd_up, cmd_wb} = puw;
    cmd_prec = prec; cmd_count_field = off; cmd_base = base;
    cmd_base_is_pc = use_pc; cmd_instr_addr = pc; cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    check(bad_encoding == (kind == 2), req, "bad_encoding pulse", {31'd0, bad_encoding}, {31'd0, kind == 2});
    check(single_xfer == (kind == 1), req, "single_xfer pulse", {31'd0, single_xfer}, {31'd0, kind == 1});
    check(addr_valid == (kind == 0), req, "addr_valid after accept", {31'd0, addr_valid}, {31'd0, kind == 0});
    @(negedge clk);
    if (kind != 0) begin
      check(!bad_encoding && !single_xfer && !addr_valid, req, "flag lasts one cycle, no address",
            {29'd0, bad_encoding, single_xfer, addr_valid}, 32'd0);
    end
    while (expq.size() != 0 || addr_valid) @(negedge clk);
    check(cmd_ready, "R1", "idle after stream", {31'd0, cmd_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!addr_valid && !bad_encoding && !single_xfer && cmd_ready, "R11", "reset state",
          {28'd0, addr_valid, bad_encoding, single_xfer, cmd_ready}, 32'd1);

    run_cmd(3'b011, 2'd0, 8'd3,  32'h0000_1000, 0, 32'h0, 0, "R2");  // increment single R3
    run_cmd(3'b101, 2'd1, 8'd4,  32'h0000_2000, 0, 32'h0, 0, "R4");  // decrement double
    run_cmd(3'b010, 2'd2, 8'd5,  32'h0000_3000, 0, 32'h0, 0, "R3");  // unindexed extended
    run_cmd(3'b011, 2'd0, 8'd2,  32'hDEAD_0000, 1, 32'h0000_8000, 0, "R7");
    run_cmd(3'b010, 2'd0, 8'd1,  32'h0000_4000, 0, 32'h0, 0, "R5");
    stall_mode = 1;
    run_cmd(3'b011, 2'd1, 8'd6,  32'h0000_5000, 0, 32'h0, 0, "R10");
    run_cmd(3'b101, 2'd2, 8'd3,  32'h0000_6000, 0, 32'h0, 0, "R6");
    stall_mode = 0;
    run_cmd(3'b100, 2'd0, 8'd2,  32'h0000_7000, 0, 32'h0, 1, "R9");
    run_cmd(3'b110, 2'd1, 8'd2,  32'h0000_7000, 0, 32'h0, 1, "R9");
    run_cmd(3'b000, 2'd0, 8'd2,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b001, 2'd0, 8'd2,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b111, 2'd1, 8'd2,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b011, 2'd3, 8'd2,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b011, 2'd0, 8'd0,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b010, 2'd2, 8'd1,  32'h0000_7000, 0, 32'h0, 2, "R8");
    run_cmd(3'b011, 2'd0, 8'd255, 32'hFFFF_FF00, 0, 32'h0, 0, "R4");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule